// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This block sits behind an instruction byte buffer and splits an unbroken byte stream into whole instructions for an instruction set whose instructions vary in length. Each instruction is an opcode of one or two bytes, followed by a chain of operand specifiers. Each specifier states its own addressing mode, and the mode decides how many parameter bytes follow it. The decoder accepts one byte per cycle on a valid/ready input. It walks the chain and emits one record per instruction on a valid/ready output. A record holds the opcode, the operand count, the operand data size, the total byte length, and for each operand the mode, the register, any index register and the parameter bytes.

An opcode table is built at elaboration from a fixed rule. It gives the operand count and the data size for each one-byte and two-byte opcode. A reserved opcode or an illegal specifier ends the instruction early with a fault record, and decoding resumes with the next byte as a new opcode. Computing effective addresses, fetching operands and executing are handled by later stages.

The controller has six states:
- OPCODE takes the first byte. It goes to OPCODE_EXT on the prefix byte, to SPEC on a legal opcode, and to EMIT on a reserved one.
- OPCODE_EXT takes the second opcode byte. It goes to SPEC or to EMIT.
- SPEC takes a specifier. It goes to BASE on an index specifier, to PARAM when the mode has parameter bytes, to SPEC for the next operand, or to EMIT after the last operand or on an illegal mode.
- BASE takes the base specifier after an index. It goes to PARAM, SPEC or EMIT by the same rules as SPEC.
- PARAM counts off parameter bytes. On the last byte it goes to SPEC or EMIT.
- EMIT presents the record. It returns to OPCODE once the record is accepted.

Top module: `vli_decoder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: For a one-byte opcode b, the operand count is b[1:0] and the size code is b[3:2] (code 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes). A count of 0, a size code of 3, or b[7:4]=F makes the opcode reserved.
- R3: The byte 0xFD marks a two-byte opcode. `out_ext` is then 1 and `out_opcode` is the second byte. The second byte follows the rule of R2, except that an upper nibble of F is allowed.
- R4: Each specifier reports its upper nibble as the mode and its lower nibble as the register. Modes 0–3 (short literal), 5, 6, 7, and modes 8 and 9 with a register other than 15, carry no parameter bytes.
- R5: Modes A/B carry 1 parameter byte, C/D carry 2 and E/F carry 4. The bytes are packed little-endian into the operand's 32-bit parameter field, first byte in bits 7:0, and the count appears in `out_plen`.
- R6: Mode 8 with register 15 (immediate) carries as many bytes as the operand data size. Mode 9 with register 15 (absolute) carries 4.
- R7: A specifier with mode 4 is an index prefix. It sets the operand's indexed flag and index register, and the next specifier is the base of the same operand. A base with mode 0–5 is illegal.
- R8: A reserved opcode, mode 5 with register 15, or an illegal base produces a record with `out_fault`=1. In that record the count, size and all operand fields are 0, and the opcode bytes already taken are kept. The next byte starts a new instruction.
- R9: `out_len` equals the number of bytes the instruction took, including the faulting byte.
- R10: Operand slots beyond the count stay all zero.
- R11: While `out_valid` is 1, `in_ready` is 0. An unaccepted record holds its value until `out_ready` is 1. A record only appears right after a byte was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Decoder can take a byte |
| in_byte | input | 8 | Instruction stream byte |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Consumer takes the record |
| out_fault | output | 1 | Reserved-instruction fault |
| out_ext | output | 1 | Two-byte opcode |
| out_opcode | output | 8 | Opcode (second byte when extended) |
| out_count | output | 2 | Operand count |
| out_size | output | 3 | Operand data size in bytes |
| out_len | output | 5 | Instruction length in bytes |
| out_mode | output | 12 | Mode per operand, 4 bits each |
| out_rnum | output | 12 | Register per operand |
| out_indexed | output | 3 | Index flag per operand |
| out_xreg | output | 12 | Index register per operand |
| out_param | output | 96 | Parameter bytes, 32 bits per operand |
| out_plen | output | 9 | Parameter byte count, 3 bits per operand |

## Verification
The bound checker checks the record properties that hold on every cycle:
- a stalled record keeps its value, and a new record only follows an accepted byte;
- a fault record is flushed;
- a good record has a nonzero count, a legal size and a length within bounds;
- unused top slots stay clear.

Only the bench scenarios can show that the byte stream is split at the right places. That covers the parameter byte counts for each mode, the immediate and absolute forms, index chaining, prefixed opcodes, and resuming cleanly after each kind of fault.

// File: rtl/ild_pkg.sv
package ild_pkg;

    localparam int unsigned OPND_SLOTS  = 3;
    localparam int unsigned PARAM_BYTES = 4;
    localparam int unsigned PARAM_W     = PARAM_BYTES * 8;
    localparam int unsigned PLEN_W      = $clog2(PARAM_BYTES + 1);
    localparam int unsigned POS_W       = $clog2(PARAM_BYTES);
    localparam int unsigned SLOT_W      = $clog2(OPND_SLOTS);
    localparam int unsigned CNT_W       = $clog2(OPND_SLOTS + 1);
    localparam int unsigned MAX_LEN     = 2 + OPND_SLOTS * (2 + PARAM_BYTES);
    localparam int unsigned LEN_W       = $clog2(MAX_LEN + 1);

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_OPCODE_EXT,
        ST_SPEC,
        ST_BASE,
        ST_PARAM,
        ST_EMIT
    } ild_state_e;

    typedef struct packed {
        logic             legal;
        logic [CNT_W-1:0] count;
        logic [2:0]       size;
    } op_info_t;

    typedef struct packed {
        logic              legal;
        logic              is_index;
        logic [PLEN_W-1:0] plen;
    } spec_info_t;

    // Opcode rule: count in bits 1:0, size code in bits 3:2.
    function automatic op_info_t op_rule(input logic ext, input logic [7:0] b);
        op_info_t r;
        r.count = CNT_W'(b[1:0]);
        case (b[3:2])
            2'd0:    r.size = 3'd1;
            2'd1:    r.size = 3'd2;
            default: r.size = 3'd4;
        endcase
        r.legal = (b[1:0] != 2'd0) && (b[3:2] != 2'd3) && (ext || (b[7:4] != 4'hF));
        return r;
    endfunction

    // Specifier rule: mode in the upper nibble, register in the lower one.
    function automatic spec_info_t spec_rule(input logic [7:0] b,
                                             input logic       after_index,
                                             input logic [2:0] dsize);
        spec_info_t r;
        r.legal    = 1'b1;
        r.is_index = 1'b0;
        r.plen     = '0;
        case (b[7:4])
            4'h0, 4'h1, 4'h2, 4'h3: r.legal = !after_index;
            4'h4: begin
                r.is_index = 1'b1;
                r.legal    = !after_index;
            end
            4'h5:       r.legal = !after_index && (b[3:0] != 4'hF);
            4'h6, 4'h7: r.plen  = '0;
            4'h8:       if (b[3:0] == 4'hF) r.plen = PLEN_W'(dsize);
            4'h9:       if (b[3:0] == 4'hF) r.plen = PLEN_W'(4);
            4'hA, 4'hB: r.plen = PLEN_W'(1);
            4'hC, 4'hD: r.plen = PLEN_W'(2);
            default:    r.plen = PLEN_W'(4);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ild_op_table.sv
module ild_op_table
    import ild_pkg::*;
(
    input  logic       ext,
    input  logic [7:0] code,
    output op_info_t   info
);
    localparam int unsigned ENTRIES = 512;

    op_info_t op_rom [ENTRIES];

    // Table contents are computed once at elaboration.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        localparam logic [8:0] IDX = 9'(i);
        assign op_rom[i] = op_rule(IDX[8], IDX[7:0]);
    end

    assign info = op_rom[{ext, code}];
endmodule

// File: rtl/ild_spec_class.sv
module ild_spec_class
    import ild_pkg::*;
(
    input  logic [7:0] spec_byte,
    input  logic       after_index,
    input  logic [2:0] dsize,
    output spec_info_t info
);
    always_comb begin
        info = spec_rule(spec_byte, after_index, dsize);
    end
endmodule

// File: rtl/ild_ctrl.sv
module ild_ctrl
    import ild_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       out_ready,
    input  logic       byte_is_prefix,
    input  logic       op_legal,
    input  spec_info_t spec,
    input  logic       last_slot,
    input  logic       param_last,
    output ild_state_e state_o,
    output logic       in_ready,
    output logic       out_valid,
    output logic       byte_fire,
    output logic       act_prefix,
    output logic       act_opcode,
    output logic       act_fault,
    output logic       act_index,
    output logic       act_spec,
    output logic       act_param,
    output logic       act_next,
    output logic       act_clear
);
    ild_state_e state_q, state_d;

    assign state_o = state_q;

    always_ff @(posedge clk or negedge rst_n) begin : state_reg
        if (!rst_n) state_q <= ST_OPCODE;
        else        state_q <= state_d;
    end

    always_comb begin : outputs
        in_ready   = (state_q != ST_EMIT);
        out_valid  = (state_q == ST_EMIT);
        byte_fire  = in_valid && in_ready;
        act_prefix = 1'b0;
        act_opcode = 1'b0;
        act_fault  = 1'b0;
        act_index  = 1'b0;
        act_spec   = 1'b0;
        act_param  = 1'b0;
        act_next   = 1'b0;
        act_clear  = 1'b0;
        unique case (state_q)
            ST_OPCODE: if (byte_fire) begin
                if (byte_is_prefix) begin
                    act_prefix = 1'b1;
                end else begin
                    act_opcode = 1'b1;
                    act_fault  = !op_legal;
                end
            end
            ST_OPCODE_EXT: if (byte_fire) begin
                act_opcode = 1'b1;
                act_fault  = !op_legal;
            end
            ST_SPEC, ST_BASE: if (byte_fire) begin
                if (!spec.legal) begin
                    act_fault = 1'b1;
                end else if (spec.is_index) begin
                    act_index = 1'b1;
                end else begin
                    act_spec = 1'b1;
                    act_next = (spec.plen == '0) && !last_slot;
                end
            end
            ST_PARAM: if (byte_fire) begin
                act_param = 1'b1;
                act_next  = param_last && !last_slot;
            end
            ST_EMIT: act_clear = out_ready;
            default: act_clear = 1'b0;
        endcase
    end

    always_comb begin : next_state
        state_d = state_q;
        unique case (state_q)
            ST_OPCODE: if (byte_fire) begin
                if (byte_is_prefix) state_d = ST_OPCODE_EXT;
                else if (!op_legal) state_d = ST_EMIT;
                else                state_d = ST_SPEC;
            end
            ST_OPCODE_EXT: if (byte_fire) begin
                state_d = op_legal ? ST_SPEC : ST_EMIT;
            end
            ST_SPEC, ST_BASE: if (byte_fire) begin
                if (!spec.legal)          state_d = ST_EMIT;
                else if (spec.is_index)   state_d = ST_BASE;
                else if (spec.plen != '0) state_d = ST_PARAM;
                else if (last_slot)       state_d = ST_EMIT;
                else                      state_d = ST_SPEC;
            end
            ST_PARAM: if (byte_fire && param_last) begin
                state_d = last_slot ? ST_EMIT : ST_SPEC;
            end
            ST_EMIT: if (out_ready) state_d = ST_OPCODE;
            default: state_d = ST_OPCODE;
        endcase
    end
endmodule

// File: rtl/ild_record.sv
module ild_record
    import ild_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [7:0]                       in_byte,
    input  logic                             byte_fire,
    input  logic                             act_prefix,
    input  logic                             act_opcode,
    input  logic                             act_fault,
    input  logic                             act_index,
    input  logic                             act_spec,
    input  logic                             act_param,
    input  logic                             act_next,
    input  logic                             act_clear,
    input  logic [CNT_W-1:0]                 op_count,
    input  logic [2:0]                       op_size,
    input  logic [PLEN_W-1:0]                spec_plen,
    output logic                             last_slot,
    output logic                             param_last,
    output logic                             rec_fault,
    output logic                             rec_ext,
    output logic [7:0]                       rec_opcode,
    output logic [CNT_W-1:0]                 rec_count,
    output logic [2:0]                       rec_size,
    output logic [LEN_W-1:0]                 rec_len,
    output logic [OPND_SLOTS*4-1:0]          rec_mode,
    output logic [OPND_SLOTS*4-1:0]          rec_rnum,
    output logic [OPND_SLOTS-1:0]            rec_indexed,
    output logic [OPND_SLOTS*4-1:0]          rec_xreg,
    output logic [OPND_SLOTS*PARAM_W-1:0]    rec_param,
    output logic [OPND_SLOTS*PLEN_W-1:0]     rec_plen
);
    logic [SLOT_W-1:0] slot_q;
    logic [PLEN_W-1:0] prm_left_q;
    logic [POS_W-1:0]  prm_pos_q;

    assign last_slot  = ((CNT_W'(slot_q) + CNT_W'(1)) == rec_count);
    assign param_last = (prm_left_q == PLEN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin : header_reg
        if (!rst_n) begin
            rec_fault  <= 1'b0;
            rec_ext    <= 1'b0;
            rec_opcode <= '0;
            rec_count  <= '0;
            rec_size   <= '0;
            rec_len    <= '0;
            slot_q     <= '0;
            prm_left_q <= '0;
            prm_pos_q  <= '0;
        end else if (act_clear) begin
            rec_fault  <= 1'b0;
            rec_ext    <= 1'b0;
            rec_opcode <= '0;
            rec_count  <= '0;
            rec_size   <= '0;
            rec_len    <= '0;
            slot_q     <= '0;
            prm_left_q <= '0;
            prm_pos_q  <= '0;
        end else begin
            if (byte_fire)  rec_len <= rec_len + LEN_W'(1);
            if (act_prefix) rec_ext <= 1'b1;
            if (act_opcode) begin
                rec_opcode <= in_byte;
                rec_count  <= op_count;
                rec_size   <= op_size;
            end
            if (act_spec) begin
                prm_left_q <= spec_plen;
                prm_pos_q  <= '0;
            end
            if (act_param) begin
                prm_left_q <= prm_left_q - PLEN_W'(1);
                prm_pos_q  <= prm_pos_q + POS_W'(1);
            end
            if (act_next) slot_q <= slot_q + SLOT_W'(1);
            if (act_fault) begin
                rec_fault <= 1'b1;
                rec_count <= '0;
                rec_size  <= '0;
            end
        end
    end

    for (genvar s = 0; s < OPND_SLOTS; s++) begin : g_slot
        localparam logic [SLOT_W-1:0] SID = SLOT_W'(s);
        logic               sel;
        logic [3:0]         mode_q;
        logic [3:0]         rnum_q;
        logic               idx_q;
        logic [3:0]         xreg_q;
        logic [PARAM_W-1:0] param_q;
        logic [PLEN_W-1:0]  plen_q;

        assign sel = (slot_q == SID);

        always_ff @(posedge clk or negedge rst_n) begin : slot_reg
            if (!rst_n) begin
                mode_q  <= '0;
                rnum_q  <= '0;
                idx_q   <= 1'b0;
                xreg_q  <= '0;
                param_q <= '0;
                plen_q  <= '0;
            end else if (act_clear || act_fault) begin
                mode_q  <= '0;
                rnum_q  <= '0;
                idx_q   <= 1'b0;
                xreg_q  <= '0;
                param_q <= '0;
                plen_q  <= '0;
            end else if (sel) begin
                if (act_index) begin
                    idx_q  <= 1'b1;
                    xreg_q <= in_byte[3:0];
                end
                if (act_spec) begin
                    mode_q <= in_byte[7:4];
                    rnum_q <= in_byte[3:0];
                    plen_q <= spec_plen;
                end
                for (int b = 0; b < PARAM_BYTES; b++) begin
                    if (act_param && (prm_pos_q == POS_W'(b))) param_q[8*b +: 8] <= in_byte;
                end
            end
        end

        assign rec_mode[4*s +: 4]             = mode_q;
        assign rec_rnum[4*s +: 4]             = rnum_q;
        assign rec_indexed[s]                 = idx_q;
        assign rec_xreg[4*s +: 4]             = xreg_q;
        assign rec_param[PARAM_W*s +: PARAM_W] = param_q;
        assign rec_plen[PLEN_W*s +: PLEN_W]   = plen_q;
    end
endmodule

// File: rtl/vli_decoder.sv
module vli_decoder
    import ild_pkg::*;
#(
    parameter logic [7:0] EXT_PREFIX = 8'hFD
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [7:0]                    in_byte,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic                          out_fault,
    output logic                          out_ext,
    output logic [7:0]                    out_opcode,
    output logic [CNT_W-1:0]              out_count,
    output logic [2:0]                    out_size,
    output logic [LEN_W-1:0]              out_len,
    output logic [OPND_SLOTS*4-1:0]       out_mode,
    output logic [OPND_SLOTS*4-1:0]       out_rnum,
    output logic [OPND_SLOTS-1:0]         out_indexed,
    output logic [OPND_SLOTS*4-1:0]       out_xreg,
    output logic [OPND_SLOTS*PARAM_W-1:0] out_param,
    output logic [OPND_SLOTS*PLEN_W-1:0]  out_plen
);
    ild_state_e state;
    op_info_t   op_info;
    spec_info_t spec_info;
    logic       byte_fire, last_slot, param_last;
    logic       act_prefix, act_opcode, act_fault, act_index;
    logic       act_spec, act_param, act_next, act_clear;

    ild_op_table u_op_table (
        .ext  (state == ST_OPCODE_EXT),
        .code (in_byte),
        .info (op_info)
    );

    ild_spec_class u_spec_class (
        .spec_byte   (in_byte),
        .after_index (state == ST_BASE),
        .dsize       (out_size),
        .info        (spec_info)
    );

    ild_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .out_ready      (out_ready),
        .byte_is_prefix (in_byte == EXT_PREFIX),
        .op_legal       (op_info.legal),
        .spec           (spec_info),
        .last_slot      (last_slot),
        .param_last     (param_last),
        .state_o        (state),
        .in_ready       (in_ready),
        .out_valid      (out_valid),
        .byte_fire      (byte_fire),
        .act_prefix     (act_prefix),
        .act_opcode     (act_opcode),
        .act_fault      (act_fault),
        .act_index      (act_index),
        .act_spec       (act_spec),
        .act_param      (act_param),
        .act_next       (act_next),
        .act_clear      (act_clear)
    );

    ild_record u_record (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_byte     (in_byte),
        .byte_fire   (byte_fire),
        .act_prefix  (act_prefix),
        .act_opcode  (act_opcode),
        .act_fault   (act_fault),
        .act_index   (act_index),
        .act_spec    (act_spec),
        .act_param   (act_param),
        .act_next    (act_next),
        .act_clear   (act_clear),
        .op_count    (op_info.count),
        .op_size     (op_info.size),
        .spec_plen   (spec_info.plen),
        .last_slot   (last_slot),
        .param_last  (param_last),
        .rec_fault   (out_fault),
        .rec_ext     (out_ext),
        .rec_opcode  (out_opcode),
        .rec_count   (out_count),
        .rec_size    (out_size),
        .rec_len     (out_len),
        .rec_mode    (out_mode),
        .rec_rnum    (out_rnum),
        .rec_indexed (out_indexed),
        .rec_xreg    (out_xreg),
        .rec_param   (out_param),
        .rec_plen    (out_plen)
    );
endmodule

// File: rtl/ild_checks.sv
module ild_checks
    import ild_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic                          in_ready,
    input logic [7:0]                    in_byte,
    input logic                          out_valid,
    input logic                          out_ready,
    input logic                          out_fault,
    input logic                          out_ext,
    input logic [7:0]                    out_opcode,
    input logic [CNT_W-1:0]              out_count,
    input logic [2:0]                    out_size,
    input logic [LEN_W-1:0]              out_len,
    input logic [OPND_SLOTS*4-1:0]       out_mode,
    input logic [OPND_SLOTS*4-1:0]       out_rnum,
    input logic [OPND_SLOTS-1:0]         out_indexed,
    input logic [OPND_SLOTS*4-1:0]       out_xreg,
    input logic [OPND_SLOTS*PARAM_W-1:0] out_param,
    input logic [OPND_SLOTS*PLEN_W-1:0]  out_plen
);
    localparam int unsigned TOP = OPND_SLOTS - 1;

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_opcode) && $stable(out_len)
            && $stable(out_param) && $stable(out_mode) && $stable(out_fault));

    assert_after_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    assert_fault_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fault |-> out_count == '0 && out_size == '0 && out_mode == '0
            && out_rnum == '0 && out_param == '0 && out_plen == '0 && out_indexed == '0);

    assert_len_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_fault |-> (out_len > LEN_W'(out_count)) && (out_len <= LEN_W'(MAX_LEN)));

    assert_count_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_fault |-> out_count != '0 && $onehot(out_size));

    assert_top_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_count != CNT_W'(OPND_SLOTS)) |->
            out_mode[4*TOP +: 4] == '0 && out_param[PARAM_W*TOP +: PARAM_W] == '0
            && out_plen[PLEN_W*TOP +: PLEN_W] == '0 && !out_indexed[TOP]);
endmodule

bind vli_decoder ild_checks u_checks (.*);

// File: tb/vli_decoder_test.sv
module vli_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  in_byte;
    logic        out_valid;
    logic        out_ready;
    logic        out_fault;
    logic        out_ext;
    logic [7:0]  out_opcode;
    logic [1:0]  out_count;
    logic [2:0]  out_size;
    logic [4:0]  out_len;
    logic [11:0] out_mode;
    logic [11:0] out_rnum;
    logic [2:0]  out_indexed;
    logic [11:0] out_xreg;
    logic [95:0] out_param;
    logic [8:0]  out_plen;

    always #5 clk = ~clk;

    vli_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .out_valid(out_valid), .out_ready(out_ready), .out_fault(out_fault), .out_ext(out_ext),
        .out_opcode(out_opcode), .out_count(out_count), .out_size(out_size), .out_len(out_len),
        .out_mode(out_mode), .out_rnum(out_rnum), .out_indexed(out_indexed), .out_xreg(out_xreg),
        .out_param(out_param), .out_plen(out_plen)
    );

    typedef struct {
        string       req;
        logic        fault;
        logic        ext;
        logic [7:0]  opc;
        logic [1:0]  cnt;
        logic [2:0]  size;
        logic [4:0]  len;
        logic [11:0] mode;
        logic [11:0] rnum;
        logic [2:0]  idx;
        logic [11:0] xreg;
        logic [95:0] param;
        logic [8:0]  plen;
    } exp_t;

    exp_t       exp_q[$];
    exp_t       cur;
    logic [7:0] ib[$];
    int         total = 0;
    int         bad = 0;
    bit         finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic new_insn(input string req, input logic ext, input logic [7:0] opc,
                            input logic [1:0] cnt, input logic [2:0] size);
        cur.req = req; cur.fault = 0; cur.ext = ext; cur.opc = opc; cur.cnt = cnt;
        cur.size = size; cur.len = 0; cur.mode = 0; cur.rnum = 0; cur.idx = 0;
        cur.xreg = 0; cur.param = 0; cur.plen = 0;
        ib.delete();
        if (ext) ib.push_back(8'hFD);
        ib.push_back(opc);
    endtask

    task automatic add_opnd(input int slot, input logic [7:0] spec, input int n,
                            input logic [31:0] val);
        ib.push_back(spec);
        for (int i = 0; i < n; i++) ib.push_back(val[8*i +: 8]);
        cur.mode[4*slot +: 4]   = spec[7:4];
        cur.rnum[4*slot +: 4]   = spec[3:0];
        cur.param[32*slot +: 32] = val;
        cur.plen[3*slot +: 3]   = 3'(n);
    endtask

    task automatic add_index(input int slot, input logic [7:0] ix);
        ib.push_back(ix);
        cur.idx[slot] = 1'b1;
        cur.xreg[4*slot +: 4] = ix[3:0];
    endtask

    task automatic raw(input logic [7:0] b);
        ib.push_back(b);
    endtask

    task automatic set_fault();
        cur.fault = 1; cur.cnt = 0; cur.size = 0;
        cur.mode = 0; cur.rnum = 0; cur.idx = 0; cur.xreg = 0; cur.param = 0; cur.plen = 0;
    endtask

    task automatic drive_byte(input logic [7:0] b);
        bit acc;
        in_byte = b;
        in_valid = 1'b1;
        forever begin
            acc = in_ready;
            @(negedge clk);
            if (acc) break;
        end
        in_valid = 1'b0;
        repeat ($urandom_range(0, 1)) @(negedge clk);
    endtask

    task automatic commit();
        cur.len = 5'(ib.size());
        exp_q.push_back(cur);
        foreach (ib[i]) drive_byte(ib[i]);
        ib.delete();
    endtask

    task automatic good_filler(input string req);
        new_insn(req, 0, 8'h01, 2'd1, 3'd1);
        add_opnd(0, 8'h51, 0, 0);
        commit();
    endtask

    task automatic compare(input exp_t e);
        check(out_fault == e.fault, e.req, "fault", out_fault, e.fault);
        check(out_ext == e.ext, e.req, "ext", out_ext, e.ext);
        check(out_opcode == e.opc, e.req, "opcode", out_opcode, e.opc);
        check(out_count == e.cnt, e.req, "count", out_count, e.cnt);
        check(out_size == e.size, e.req, "size", out_size, e.size);
        check(out_len == e.len, {e.req, "/R9"}, "len", out_len, e.len);
        check(out_mode == e.mode, e.req, "mode", out_mode, e.mode);
        check(out_rnum == e.rnum, e.req, "rnum", out_rnum, e.rnum);
        check(out_indexed == e.idx, e.req, "indexed", out_indexed, e.idx);
        check(out_xreg == e.xreg, e.req, "xreg", out_xreg, e.xreg);
        check(out_param == e.param, {e.req, "/R10"}, "param", out_param, e.param);
        check(out_plen == e.plen, {e.req, "/R10"}, "plen", out_plen, e.plen);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Monitor: pops expected records when the design hands one over.
    initial begin : monitor
        bit          rdy;
        bit          hold;
        logic [4:0]  s_len;
        logic [7:0]  s_opc;
        logic [95:0] s_param;
        exp_t        e;
        hold = 0;
        out_ready = 1'b0;
        wait (rst_n === 1'b1);
        forever begin
            @(negedge clk);
            if (hold) begin
                // R11: a stalled record keeps its value
                check(out_valid && out_len == s_len && out_opcode == s_opc && out_param == s_param,
                      "R11", "stalled record changed", {out_valid, out_len, out_opcode},
                      {1'b1, s_len, s_opc});
            end
            hold = 0;
            if (out_valid) begin
                check(!in_ready, "R11", "in_ready during record", in_ready, 0);
                rdy = ($urandom_range(0, 3) != 0);
                if (rdy) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R11", "unexpected record", out_opcode, 0);
                    end else begin
                        e = exp_q.pop_front();
                        compare(e);
                    end
                end else begin
                    hold = 1;
                    s_len = out_len; s_opc = out_opcode; s_param = out_param;
                end
            end else begin
                rdy = ($urandom_range(0, 1) != 0);
            end
            out_ready = rdy;
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
        end
    end

    initial begin : driver
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_byte = 8'h00;
        repeat (3) @(negedge clk);
        check(!out_valid && in_ready, "R1", "state in reset", {out_valid, in_ready}, 2'b01);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R1", "state after reset", {out_valid, in_ready}, 2'b01);

        // R2 / R4: one-byte opcodes with plain specifiers
        new_insn("R2", 0, 8'h01, 2'd1, 3'd1); add_opnd(0, 8'h51, 0, 0); commit();
        new_insn("R4", 0, 8'h06, 2'd2, 3'd2); add_opnd(0, 8'h0A, 0, 0); add_opnd(1, 8'h63, 0, 0); commit();
        new_insn("R4", 0, 8'h0A, 2'd2, 3'd4); add_opnd(0, 8'h77, 0, 0); add_opnd(1, 8'h82, 0, 0); commit();
        new_insn("R4", 0, 8'h05, 2'd1, 3'd2); add_opnd(0, 8'h91, 0, 0); commit();

        // R5: byte, word and longword displacements in three slots
        new_insn("R5", 0, 8'h0B, 2'd3, 3'd4);
        add_opnd(0, 8'hA2, 1, 32'h0000_007F);
        add_opnd(1, 8'hC3, 2, 32'h0000_1234);
        add_opnd(2, 8'hE4, 4, 32'hDEAD_BEEF);
        commit();
        new_insn("R5", 0, 8'h02, 2'd2, 3'd1);
        add_opnd(0, 8'hDB, 2, 32'h0000_8001); add_opnd(1, 8'hF0, 4, 32'h0102_0304); commit();

        // R6: immediate follows data size, absolute is always four bytes
        new_insn("R6", 0, 8'h05, 2'd1, 3'd2); add_opnd(0, 8'h8F, 2, 32'h0000_BEEF); commit();
        new_insn("R6", 0, 8'h09, 2'd1, 3'd4); add_opnd(0, 8'h8F, 4, 32'hCAFE_F00D); commit();
        new_insn("R6", 0, 8'h01, 2'd1, 3'd1); add_opnd(0, 8'h8F, 1, 32'h0000_005A); commit();
        new_insn("R6", 0, 8'h01, 2'd1, 3'd1); add_opnd(0, 8'h9F, 4, 32'h0000_1000); commit();

        // R3: prefixed opcodes
        new_insn("R3", 1, 8'h22, 2'd2, 3'd1); add_opnd(0, 8'h53, 0, 0); add_opnd(1, 8'hB1, 1, 32'h80); commit();
        new_insn("R3", 1, 8'hF5, 2'd1, 3'd2); add_opnd(0, 8'hC0, 2, 32'h0000_A55A); commit();

        // R7: index prefix joined to its base
        new_insn("R7", 0, 8'h02, 2'd2, 3'd1);
        add_index(0, 8'h44); add_opnd(0, 8'hA5, 1, 32'h10); add_opnd(1, 8'h56, 0, 0); commit();
        new_insn("R7", 0, 8'h05, 2'd1, 3'd2);
        add_index(0, 8'h47); add_opnd(0, 8'h8F, 2, 32'h0000_4321); commit();

        // R8: faults, each followed by a clean instruction
        new_insn("R8", 0, 8'h00, 2'd0, 3'd0); set_fault(); commit(); good_filler("R8");
        new_insn("R8", 0, 8'h0D, 2'd1, 3'd0); set_fault(); commit(); good_filler("R8");
        new_insn("R8", 0, 8'hF1, 2'd1, 3'd0); set_fault(); commit(); good_filler("R8");
        new_insn("R8", 1, 8'h00, 2'd0, 3'd0); set_fault(); commit(); good_filler("R8");
        new_insn("R8", 0, 8'h01, 2'd1, 3'd1); raw(8'h5F); set_fault(); commit(); good_filler("R8");
        new_insn("R8", 0, 8'h02, 2'd2, 3'd1); raw(8'hA1); raw(8'h05); raw(8'h44); raw(8'h51);
        set_fault(); commit(); good_filler("R8");
        new_insn("R8", 0, 8'h02, 2'd2, 3'd1); raw(8'h44); raw(8'h43); set_fault(); commit();
        good_filler("R8");
        new_insn("R8", 0, 8'h01, 2'd1, 3'd1); raw(8'h41); raw(8'h44); set_fault(); commit();
        good_filler("R8");

        wait (exp_q.size() == 0);
        repeat (6) @(negedge clk);
        check(!out_valid, "R11", "extra record after stream", out_valid, 0);
        finished = 1;
        summary();
    end
endmodule